// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register and arithmetic half of a small processor in which every transfer crosses one shared internal bus. It holds a program counter, a memory address register, a memory data register, an instruction register, a small general register file and an adder/logic unit. The adder's first operand is a staging register Y and its second operand is taken straight off the bus. Its result lands only in a holding register Z, and Z must be gated back onto the bus to reach any other register. Each register has an "out" strobe that places it on the bus and an "in" strobe that captures the bus at the clock edge.

An external sequencer drives the strobes one step per clock, and in this project the testbench plays that role. Instruction fetch increments the PC by reusing the adder: Y is forced to zero, carry-in is set, and an add is selected while the PC is on the bus. Instruction words have three fields: an opcode, a memory address field and a register select field. The address field can drive the bus either as a direct address or, sign-extended, as a PC-relative branch offset. The register field picks the general register used by the register file strobes.

Memory reads use a request/acknowledge pair. A read is requested when MAR is loaded. The request stays up until the memory signals function complete, and at that point the returned word is captured in MDR. Add and subtract results update a three-bit condition code that the sequencer can test to resolve conditional branches.

Top module: `sbus_datapath`

## Requirements
- R1: After the asynchronous active-low reset, PC, MAR, MDR, IR, Y, Z, every general register and the condition code are zero, and no memory read is requested.
- R2: The bus carries the value of the single source whose out strobe is active. With no out strobe active, the bus reads zero.
- R3: When the address-field out strobe is active, the bus carries IR bits [9:2] sign-extended to 16 bits.
- R4: With alu_op 00 (add), the unit forms Y + bus + carry-in. When clear-Y is active, zero is used in place of Y, so clear-Y with carry-in and add gives bus + 1.
- R5: alu_op 01 gives Y minus bus, 10 gives Y AND bus, and 11 gives Y OR bus. Carry-in has no effect on these three.
- R6: Every in strobe loads its register from the bus at the next clock edge. The register file strobes read and write the general register selected by IR bits [1:0].
- R7: A cycle with the read strobe raises mem_read_o from the next cycle on, with mem_addr_o equal to MAR. The request holds until mem_mfc_i is seen, and on that edge MDR captures mem_rdata_i and the request drops. mem_mfc_i with no request pending leaves MDR unchanged.
- R8: When Z is loaded with an add or subtract, cc_o becomes {N, Z, V}: bit 2 is the result sign, bit 1 is set for a zero result, and bit 0 is signed overflow. A Z load with AND or OR leaves cc_o unchanged.
- R9: ir_o always shows the full instruction register.
- R10: Z changes only on a cycle with its in strobe active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_out_i | input | 1 | Drive PC onto bus |
| pc_in_i | input | 1 | Load PC from bus |
| mar_in_i | input | 1 | Load MAR from bus |
| mdr_out_i | input | 1 | Drive MDR onto bus |
| ir_in_i | input | 1 | Load IR from bus |
| ir_addr_out_i | input | 1 | Drive sign-extended IR address field onto bus |
| rf_out_i | input | 1 | Drive selected general register onto bus |
| rf_in_i | input | 1 | Load selected general register from bus |
| y_in_i | input | 1 | Load Y from bus |
| z_out_i | input | 1 | Drive Z onto bus |
| z_in_i | input | 1 | Load Z from ALU result |
| clr_y_i | input | 1 | Use zero in place of Y as ALU operand |
| cin_i | input | 1 | Adder carry-in for add |
| alu_op_i | input | 2 | 00 add, 01 subtract, 10 AND, 11 OR |
| read_i | input | 1 | Request a memory read at MAR |
| mem_addr_o | output | 8 | Memory address (MAR) |
| mem_read_o | output | 1 | Read request pending |
| mem_rdata_i | input | 16 | Memory read data |
| mem_mfc_i | input | 1 | Memory function complete |
| bus_o | output | 16 | Internal bus value |
| ir_o | output | 16 | Instruction register |
| cc_o | output | 3 | Condition code {N, Z, V} |

## Verification
The assertions assume that the sequencer never enables more than one out strobe in the same cycle, and that memory raises function complete only while a read is pending. The bench keeps within both limits by construction: every control step is built from a fixed strobe mask that names at most one source. Its memory model raises the acknowledge a fixed number of cycles after the request rises. The single deliberate acknowledge issued with no read pending happens with the one-hot check satisfied, and it is used only to show that MDR ignores it.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_AND = 2'b10,
    ALU_OR  = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
  } cc_t;

  localparam int unsigned SRC_PC  = 0;
  localparam int unsigned SRC_MDR = 1;
  localparam int unsigned SRC_IRA = 2;
  localparam int unsigned SRC_RF  = 3;
  localparam int unsigned SRC_Z   = 4;
  localparam int unsigned NSRC    = 5;
endpackage

// File: rtl/sbus_alu.sv
module sbus_alu import sbus_pkg::*; #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              clr_y_i,
  input  logic              cin_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] res_o,
  output cc_t               flags_o,
  output logic              arith_o
);
  logic [DATA_W-1:0] a_op, b_eff, sum;
  logic              c_eff;

  always_comb begin
    a_op  = clr_y_i ? '0 : y_i;
    b_eff = (op_i == ALU_SUB) ? ~bus_i : bus_i;
    c_eff = (op_i == ALU_SUB) ? 1'b1 : cin_i;
    sum   = a_op + b_eff + {{(DATA_W-1){1'b0}}, c_eff};
    unique case (op_i)
      ALU_ADD, ALU_SUB: res_o = sum;
      ALU_AND:          res_o = a_op & bus_i;
      default:          res_o = a_op | bus_i;
    endcase
    arith_o   = (op_i == ALU_ADD) || (op_i == ALU_SUB);
    flags_o.n = sum[DATA_W-1];
    flags_o.z = (sum == '0);
    flags_o.v = (a_op[DATA_W-1] == b_eff[DATA_W-1]) && (sum[DATA_W-1] != a_op[DATA_W-1]);
  end
endmodule

// File: rtl/sbus_bus_mux.sv
module sbus_bus_mux #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N      = 5
) (
  input  logic [N-1:0]             sel_i,
  input  logic [N-1:0][DATA_W-1:0] src_i,
  output logic [DATA_W-1:0]        bus_o
);
  // AND-OR tree: idle bus is zero
  always_comb begin
    bus_o = '0;
    for (int i = 0; i < N; i++) begin
      bus_o = bus_o | (src_i[i] & {DATA_W{sel_i[i]}});
    end
  end
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREGS  = 4,
  localparam int unsigned SEL_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NREGS-1:0][DATA_W-1:0] regs_q;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            regs_q[g] <= '0;
      else if (we_i && (sel_i == SEL_W'(g)))  regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[sel_i];

  p_rf_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o == $past(wdata_i) || sel_i != $past(sel_i));
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath import sbus_pkg::*; #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned MADDR_W = 8,
  parameter int unsigned NREGS   = 4,
  localparam int unsigned SEL_W  = $clog2(NREGS),
  localparam int unsigned AF_LSB = SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pc_out_i,
  input  logic               pc_in_i,
  input  logic               mar_in_i,
  input  logic               mdr_out_i,
  input  logic               ir_in_i,
  input  logic               ir_addr_out_i,
  input  logic               rf_out_i,
  input  logic               rf_in_i,
  input  logic               y_in_i,
  input  logic               z_out_i,
  input  logic               z_in_i,
  input  logic               clr_y_i,
  input  logic               cin_i,
  input  logic [1:0]         alu_op_i,
  input  logic               read_i,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic               mem_read_o,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  input  logic               mem_mfc_i,
  output logic [DATA_W-1:0]  bus_o,
  output logic [DATA_W-1:0]  ir_o,
  output logic [2:0]         cc_o
);
  logic [DATA_W-1:0]  pc_q, mdr_q, ir_q, y_q, z_q;
  logic [MADDR_W-1:0] mar_q;
  cc_t                cc_q;
  logic               rd_pend_q;

  logic [NSRC-1:0]             out_sel;
  logic [NSRC-1:0][DATA_W-1:0] src;
  logic [DATA_W-1:0]           bus, rf_rdata, alu_res, ir_addr_sx;
  cc_t                         alu_flags;
  logic                        alu_arith;
  alu_op_e                     op;

  assign op = alu_op_e'(alu_op_i);
  assign ir_addr_sx = {{(DATA_W-MADDR_W){ir_q[AF_LSB+MADDR_W-1]}}, ir_q[AF_LSB +: MADDR_W]};

  always_comb begin
    out_sel          = '0;
    out_sel[SRC_PC]  = pc_out_i;
    out_sel[SRC_MDR] = mdr_out_i;
    out_sel[SRC_IRA] = ir_addr_out_i;
    out_sel[SRC_RF]  = rf_out_i;
    out_sel[SRC_Z]   = z_out_i;
    src          = '0;
    src[SRC_PC]  = pc_q;
    src[SRC_MDR] = mdr_q;
    src[SRC_IRA] = ir_addr_sx;
    src[SRC_RF]  = rf_rdata;
    src[SRC_Z]   = z_q;
  end

  sbus_bus_mux #(.DATA_W(DATA_W), .N(NSRC)) u_mux (
    .sel_i (out_sel),
    .src_i (src),
    .bus_o (bus)
  );

  sbus_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (ir_q[SEL_W-1:0]),
    .we_i    (rf_in_i),
    .wdata_i (bus),
    .rdata_o (rf_rdata)
  );

  sbus_alu #(.DATA_W(DATA_W)) u_alu (
    .y_i     (y_q),
    .bus_i   (bus),
    .clr_y_i (clr_y_i),
    .cin_i   (cin_i),
    .op_i    (op),
    .res_o   (alu_res),
    .flags_o (alu_flags),
    .arith_o (alu_arith)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0; mar_q <= '0; mdr_q <= '0; ir_q <= '0;
      y_q  <= '0; z_q   <= '0; cc_q  <= '0; rd_pend_q <= 1'b0;
    end else begin
      if (pc_in_i)  pc_q  <= bus;
      if (mar_in_i) mar_q <= bus[MADDR_W-1:0];
      if (ir_in_i)  ir_q  <= bus;
      if (y_in_i)   y_q   <= bus;
      if (z_in_i)   z_q   <= alu_res;
      if (z_in_i && alu_arith) cc_q <= alu_flags;
      if (read_i)                      rd_pend_q <= 1'b1;
      else if (rd_pend_q && mem_mfc_i) rd_pend_q <= 1'b0;
      if (rd_pend_q && mem_mfc_i) mdr_q <= mem_rdata_i;
    end
  end

  assign mem_addr_o = mar_q;
  assign mem_read_o = rd_pend_q;
  assign bus_o      = bus;
  assign ir_o       = ir_q;
  assign cc_o       = cc_q;

  p_one_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(out_sel));
  p_idle_bus_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sel == '0) |-> (bus_o == '0));
  p_incr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_y_i && cin_i && op == ALU_ADD) |-> alu_res == bus + DATA_W'(1));
  p_pc_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_in_i |=> pc_q == $past(bus));
  p_read_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_i |=> mem_read_o);
  p_read_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_read_o && mem_mfc_i && !read_i) |=> !mem_read_o);
  p_mdr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_read_o && mem_mfc_i) |=> $stable(mdr_q));
  p_cc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(z_in_i && (op == ALU_ADD || op == ALU_SUB)) |=> $stable(cc_o));
  p_z_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !z_in_i |=> $stable(z_q));
endmodule

// File: tb/sbus_datapath_tb.sv
module sbus_datapath_tb_top;
  localparam logic [13:0] M_PCO = 14'h0001, M_PCI = 14'h0002, M_MARI = 14'h0004,
                          M_MDRO = 14'h0008, M_IRI = 14'h0010, M_IRAO = 14'h0020,
                          M_RFO = 14'h0040, M_RFI = 14'h0080, M_YI = 14'h0100,
                          M_ZO = 14'h0200, M_ZI = 14'h0400, M_CLRY = 14'h0800,
                          M_CIN = 14'h1000, M_RD = 14'h2000;
  localparam logic [1:0] OP_ADD = 2'b00, OP_SUB = 2'b01, OP_AND = 2'b10, OP_OR = 2'b11;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [13:0] ctl = '0;
  logic [1:0]  op = '0;
  logic [7:0]  mem_addr;
  logic        mem_read, mem_mfc, mfc_force = 1'b0;
  logic [15:0] mem_rdata, bus, ir;
  logic [2:0]  cc;
  logic [15:0] mem [256];
  logic [1:0]  lat;
  int          total = 0, bad = 0;

  always #10 clk = ~clk;

  always @(posedge clk) lat <= mem_read ? lat + 2'd1 : 2'd0;
  assign mem_mfc   = (mem_read && lat == 2'd2) || mfc_force;
  assign mem_rdata = mfc_force ? 16'hDEAD : mem[mem_addr];

  sbus_datapath dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .pc_out_i(ctl[0]), .pc_in_i(ctl[1]), .mar_in_i(ctl[2]), .mdr_out_i(ctl[3]),
    .ir_in_i(ctl[4]), .ir_addr_out_i(ctl[5]), .rf_out_i(ctl[6]), .rf_in_i(ctl[7]),
    .y_in_i(ctl[8]), .z_out_i(ctl[9]), .z_in_i(ctl[10]), .clr_y_i(ctl[11]),
    .cin_i(ctl[12]), .alu_op_i(op), .read_i(ctl[13]),
    .mem_addr_o(mem_addr), .mem_read_o(mem_read), .mem_rdata_i(mem_rdata),
    .mem_mfc_i(mem_mfc), .bus_o(bus), .ir_o(ir), .cc_o(cc)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [13:0] c, input logic [1:0] o);
    ctl = c; op = o;
    @(posedge clk); #2;
    ctl = '0; op = OP_ADD;
  endtask

  // drive one out strobe without a clock edge and sample the bus
  task automatic peek(input logic [13:0] c, input logic [15:0] exp, input string req);
    ctl = c; #2;
    check(req, bus, exp);
    ctl = '0; #1;
  endtask

  task automatic wait_mfc(input logic [7:0] addr);
    while (!mem_mfc) begin
      check("R7 req held", {15'd0, mem_read}, 16'd1);
      check("R7 addr", {8'd0, mem_addr}, {8'd0, addr});
      @(posedge clk); #2;
    end
    @(posedge clk); #2;
    check("R7 req drop", {15'd0, mem_read}, 16'd0);
  endtask

  task automatic fetch(input logic [15:0] pc, input logic [15:0] instr);
    step(M_PCO | M_MARI | M_RD | M_CLRY | M_CIN | M_ZI, OP_ADD);
    step(M_ZO | M_PCI, OP_ADD);
    wait_mfc(pc[7:0]);
    step(M_MDRO | M_IRI, OP_ADD);
    check("R9 ir", ir, instr);
    peek(M_PCO, pc + 16'd1, "R4 pc+1");
  endtask

  task automatic t_reset;
    check("R1 ir", ir, 16'h0);
    check("R1 cc", {13'd0, cc}, 16'h0);
    check("R1 read", {15'd0, mem_read}, 16'h0);
    check("R1/R2 idle bus", bus, 16'h0);
    peek(M_PCO, 16'h0, "R1 pc");
    peek(M_ZO, 16'h0, "R1 z");
    peek(M_MDRO, 16'h0, "R1 mdr");
    peek(M_RFO, 16'h0, "R1 reg");
  endtask

  task automatic t_add_instr;
    fetch(16'h0000, 16'h0501);
    // preload R1 from mem[0x40]
    step(M_IRAO | M_MARI | M_RD, OP_ADD);
    wait_mfc(8'h40);
    peek(M_MDRO, 16'h1234, "R7 mdr capture");
    step(M_MDRO | M_RFI, OP_ADD);
    peek(M_RFO, 16'h1234, "R6 reg write");
    // add R1 + mem[0x40]
    step(M_IRAO | M_MARI | M_RD, OP_ADD);
    step(M_RFO | M_YI, OP_ADD);
    wait_mfc(8'h40);
    step(M_MDRO | M_ZI, OP_ADD);
    step(M_ZO | M_RFI, OP_ADD);
    peek(M_RFO, 16'h2468, "R4 add result");
    check("R8 cc add", {13'd0, cc}, 16'h0);
  endtask

  task automatic t_branch;
    fetch(16'h0001, 16'h0BF2);
    peek(M_IRAO, 16'hFFFC, "R3 sign extend");
    peek(M_RFO, 16'h0000, "R6 reg field select");
    step(M_PCO | M_YI, OP_ADD);
    step(M_IRAO | M_ZI, OP_ADD);
    step(M_ZO | M_PCI, OP_ADD);
    peek(M_PCO, 16'hFFFE, "R6 branch target");
    check("R8 cc neg", {13'd0, cc}, 16'h0004);
  endtask

  task automatic t_logic_ops;
    step(M_PCO | M_YI, OP_ADD);                 // Y = FFFE
    step(M_IRAO | M_ZI | M_CIN, OP_SUB);        // FFFE - FFFC
    peek(M_ZO, 16'h0002, "R5 sub");
    check("R8 cc sub", {13'd0, cc}, 16'h0);
    step(M_IRAO | M_ZI | M_CIN, OP_AND);
    peek(M_ZO, 16'hFFFC, "R5 and");
    step(M_PCO | M_ZI, OP_OR);
    peek(M_ZO, 16'hFFFE, "R5 or");
    check("R8 cc logic hold", {13'd0, cc}, 16'h0);
    step(M_PCO | M_ZI, OP_SUB);
    peek(M_ZO, 16'h0000, "R5 sub zero");
    check("R8 cc zero", {13'd0, cc}, 16'h0002);
    step(M_PCO, OP_ADD);                        // ALU active, no Zin
    peek(M_ZO, 16'h0000, "R10 z hold");
  endtask

  task automatic t_overflow;
    step(M_MARI | M_RD | M_IRAO, OP_ADD);       // address field still 0xFC
    wait_mfc(8'hFC);
    step(M_MDRO | M_YI, OP_ADD);
    step(M_MDRO | M_ZI, OP_ADD);
    peek(M_ZO, 16'hFFFE, "R4 add 7fff+7fff");
    check("R8 cc ovf", {13'd0, cc}, 16'h0005);
    step(M_MDRO | M_ZI, OP_AND);
    check("R8 cc and hold", {13'd0, cc}, 16'h0005);
    step(M_CLRY | M_MDRO | M_ZI, OP_ADD);
    peek(M_ZO, 16'h7FFF, "R4 clear y");
  endtask

  task automatic t_stray_mfc;
    mfc_force = 1'b1;
    @(posedge clk); #2;
    mfc_force = 1'b0;
    peek(M_MDRO, 16'h7FFF, "R7 stray mfc ignored");
    check("R7 no req", {15'd0, mem_read}, 16'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3);
    mem[8'h00] = 16'h0501;
    mem[8'h01] = 16'h0BF2;
    mem[8'h40] = 16'h1234;
    mem[8'hFC] = 16'h7FFF;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_add_instr();
    t_branch();
    t_logic_ops();
    t_overflow();
    t_stray_mfc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule